// File: doc/BRIEF.md
# Dual-Edge Phase-Shift PWM Core

This block produces a pulse-width-modulated output whose edge placement is finer than one period of its counter clock. A carrier counter on the zero-phase clock sets the period. A small state machine drives a coarse reference pulse that lasts a whole number of counter cycles. That pulse is then lengthened by a fraction of a cycle. Two retiming flip-flops do this. One samples on the rising edge of a phase-shifted copy of the counter clock and the other on its falling edge. Gating in front of them chooses which one may carry the pulse, so no selector sits behind the registers. Using both edges gives a step of one counter period divided by 2^(PH_W+1).

The duty word has three fields. The upper field is the coarse count. The bit below it picks the falling-edge flip-flop. The lowest PH_W bits name the phase of the shifted clock, which a clock selector outside this block must supply. The core reads the duty word only when the counter wraps. It clamps oversized words to a full period.

The reference state machine has four states: `ST_OFF` (coarse field zero, reference low all period), `ST_PULSE` (reference high), `ST_REST` (reference low after the pulse) and `ST_FULL` (reference high all period). At every wrap the next state is chosen from the new coarse field: `ST_OFF` for zero, `ST_FULL` for the period length, `ST_PULSE` otherwise. Inside a period there is one transition, `ST_PULSE` to `ST_REST`, taken when the counter reaches the coarse count. Every other state holds until the next wrap.

Top module: `dpwm_dual_edge`

## Requirements
- R1: While rst_n is low, pwm_out is 0. After release the latched duty is 0, so pwm_out stays low for the first counter period.
- R2: The carrier counter steps 0, 1, ..., PERIOD-1 on rising clk0 and then returns to 0. A pulsing output therefore repeats every PERIOD clk0 cycles.
- R3: The duty word is split as follows. Bits [DUTY_W-1:PH_W+1] are the coarse count C. Bit [PH_W] is the edge bit E. Bits [PH_W-1:0] are the phase P. The reference is high from the wrap edge for exactly C clk0 cycles.
- R4: With E = 0, the rising-edge flip-flop stretches the pulse. The width is C·Tc + P·Tp plus the fixed lag of clk_ph, with Tp = Tc/2^(PH_W+1). Here clk_ph lags clk0 by P·Tp plus that fixed lag.
- R5: With E = 1, the falling-edge flip-flop stretches the pulse. The width is C·Tc + (2^PH_W + P)·Tp plus the same fixed lag.
- R6: The rising-edge and falling-edge flip-flops are never high together.
- R7: The duty word is sampled only at the wrap edge. A change made mid-period, or half a cycle after the wrap, takes effect in the next period. A change made half a cycle before the wrap takes effect in the period that starts at that wrap.
- R8: A word above PERIOD·2^(PH_W+1) is treated as exactly that value. Such a word, or that value itself, holds pwm_out high for the whole period.
- R9: A coarse count of 0 holds pwm_out low whatever E and P are. This includes a duty word of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk0 | input | 1 | Zero-phase counter clock |
| clk_ph | input | 1 | Phase-shifted copy of clk0 chosen by the phase field |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_in | input | DUTY_W | Duty word: coarse count, edge bit, phase |
| pwm_out | output | 1 | High-resolution PWM output |

## Verification
Two things happen on the same clk0 edge: the duty word is sampled, and the next reference pulse starts. The bench exercises this by writing a new word half a cycle before the wrap and again half a cycle after it. It also writes a new word in the middle of a running pulse. Each case is judged by measuring, in simulation time, the width of every pulse around the change and checking it against the old or new word as R7 requires. A second overlap can occur when a saturated period runs into a stretched one, because the retiming flip-flops carry the reference across the wrap. The bench steps between full, off and pulsing words, measures each resulting width, and checks the levels at the port.

// File: rtl/dpwm_pkg.sv
`timescale 1ns/1ps
package dpwm_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_PULSE = 2'd1,
        ST_REST  = 2'd2,
        ST_FULL  = 2'd3
    } ref_state_e;
endpackage

// File: rtl/dpwm_carrier.sv
`timescale 1ns/1ps
// Carrier counter on the zero-phase clock, with duty capture and clamping at the wrap.
module dpwm_carrier #(
    parameter int PERIOD = 200,
    parameter int DUTY_W = 12,
    parameter int PH_W   = 3
) (
    input  logic                                clk0,
    input  logic                                rst_n,
    input  logic [DUTY_W-1:0]                   duty_in,
    output logic                                wrap,
    output logic [$clog2(PERIOD+1)-1:0]         cnt_q,
    output logic [DUTY_W-PH_W-2:0]              coarse_q,
    output logic [DUTY_W-PH_W-2:0]              coarse_nx,
    output logic                                edge_q
);
    localparam int CW    = DUTY_W - PH_W - 1;
    localparam int CNT_W = $clog2(PERIOD + 1);
    localparam logic [DUTY_W-1:0] FULL_WORD = DUTY_W'(PERIOD * (2 ** (PH_W + 1)));

    logic sat;
    logic edge_nx;

    assign wrap = (cnt_q == CNT_W'(PERIOD - 1));

    always_comb begin
        sat       = (duty_in > FULL_WORD);
        coarse_nx = sat ? CW'(PERIOD) : duty_in[DUTY_W-1:PH_W+1];
        edge_nx   = sat ? 1'b0 : duty_in[PH_W];
    end

    always_ff @(posedge clk0 or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            coarse_q <= '0;
            edge_q   <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            coarse_q <= coarse_nx;
            edge_q   <= edge_nx;
        end else begin
            cnt_q    <= cnt_q + CNT_W'(1);
        end
    end

    a_r2_wrap_to_zero: assert property (@(posedge clk0) disable iff (!rst_n)
        (cnt_q == CNT_W'(PERIOD - 1)) |=> (cnt_q == '0));

    a_r2_step_by_one: assert property (@(posedge clk0) disable iff (!rst_n)
        (cnt_q != CNT_W'(PERIOD - 1)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    a_r7_hold_mid_period: assert property (@(posedge clk0) disable iff (!rst_n)
        (cnt_q != CNT_W'(PERIOD - 1)) |=> ($stable(coarse_q) && $stable(edge_q)));

    a_r8_coarse_bound: assert property (@(posedge clk0) disable iff (!rst_n)
        (coarse_q <= CW'(PERIOD)) && !((coarse_q == CW'(PERIOD)) && edge_q));
endmodule

// File: rtl/dpwm_ref_fsm.sv
`timescale 1ns/1ps
// Coarse reference pulse generator.
module dpwm_ref_fsm
    import dpwm_pkg::*;
#(
    parameter int PERIOD = 200,
    parameter int CW     = 8,
    parameter int CNT_W  = 8
) (
    input  logic             clk0,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CW-1:0]    coarse_q,
    input  logic [CW-1:0]    coarse_nx,
    output logic             ref_o
);
    localparam int CMP_W = (CW > CNT_W) ? CW : CNT_W;

    ref_state_e state_q, state_d;
    logic [CMP_W-1:0] cnt_next;

    always_ff @(posedge clk0 or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        cnt_next = CMP_W'(cnt_q) + CMP_W'(1);
        state_d  = state_q;
        if (wrap) begin
            if (coarse_nx == '0)
                state_d = ST_OFF;
            else if (coarse_nx == CW'(PERIOD))
                state_d = ST_FULL;
            else
                state_d = ST_PULSE;
        end else begin
            unique case (state_q)
                ST_OFF:   state_d = ST_OFF;
                ST_PULSE: state_d = (cnt_next == CMP_W'(coarse_q)) ? ST_REST : ST_PULSE;
                ST_REST:  state_d = ST_REST;
                ST_FULL:  state_d = ST_FULL;
                default:  state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_PULSE, ST_FULL: ref_o = 1'b1;
            default:           ref_o = 1'b0;
        endcase
    end

    a_r3_ref_tracks_count: assert property (@(posedge clk0) disable iff (!rst_n)
        ref_o == (CMP_W'(coarse_q) > CMP_W'(cnt_q)));

    a_r9_off_stays_low: assert property (@(posedge clk0) disable iff (!rst_n)
        (coarse_q == '0) |-> !ref_o);
endmodule

// File: rtl/dpwm_edge_tap.sv
`timescale 1ns/1ps
// One retiming flip-flop on the phase clock. FALLING picks the clock edge.
module dpwm_edge_tap #(
    parameter bit FALLING = 1'b0
) (
    input  logic clk_ph,
    input  logic rst_n,
    input  logic ref_i,
    input  logic edge_i,
    output logic tap_o
);
    logic gated;

    assign gated = ref_i & (edge_i == FALLING);

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge clk_ph or negedge rst_n) begin
                if (!rst_n) tap_o <= 1'b0;
                else        tap_o <= gated;
            end
        end else begin : g_rise
            always_ff @(posedge clk_ph or negedge rst_n) begin
                if (!rst_n) tap_o <= 1'b0;
                else        tap_o <= gated;
            end
        end
    endgenerate
endmodule

// File: rtl/dpwm_dual_edge.sv
`timescale 1ns/1ps
// Dual-edge phase-shift PWM core: coarse reference ORed with two retimed copies.
module dpwm_dual_edge #(
    parameter int PERIOD = 200,
    parameter int DUTY_W = 12,
    parameter int PH_W   = 3
) (
    input  logic              clk0,
    input  logic              clk_ph,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              pwm_out
);
    localparam int CW    = DUTY_W - PH_W - 1;
    localparam int CNT_W = $clog2(PERIOD + 1);

    logic             wrap;
    logic [CNT_W-1:0] cnt_q;
    logic [CW-1:0]    coarse_q;
    logic [CW-1:0]    coarse_nx;
    logic             edge_q;
    logic             ref_p;
    logic [1:0]       taps;

    dpwm_carrier #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .PH_W(PH_W)) u_carrier (
        .clk0(clk0), .rst_n(rst_n), .duty_in(duty_in), .wrap(wrap),
        .cnt_q(cnt_q), .coarse_q(coarse_q), .coarse_nx(coarse_nx), .edge_q(edge_q)
    );

    dpwm_ref_fsm #(.PERIOD(PERIOD), .CW(CW), .CNT_W(CNT_W)) u_ref (
        .clk0(clk0), .rst_n(rst_n), .wrap(wrap), .cnt_q(cnt_q),
        .coarse_q(coarse_q), .coarse_nx(coarse_nx), .ref_o(ref_p)
    );

    for (genvar g = 0; g < 2; g++) begin : g_tap
        dpwm_edge_tap #(.FALLING(g == 1)) u_tap (
            .clk_ph(clk_ph), .rst_n(rst_n), .ref_i(ref_p),
            .edge_i(edge_q), .tap_o(taps[g])
        );
    end

    assign pwm_out = ref_p | taps[0] | taps[1];

    a_r6_single_tap: assert property (@(posedge clk0) disable iff (!rst_n)
        $onehot0(taps));

    a_r9_port_low_when_off: assert property (@(posedge clk0) disable iff (!rst_n)
        (coarse_q == '0) |-> !pwm_out);
endmodule

// File: tb/test_dpwm_dual_edge.sv
`timescale 1ns/1ps
module test_dpwm_dual_edge;
    localparam int PERIOD  = 24;
    localparam int DUTY_W  = 10;
    localparam int PH_W    = 3;
    localparam int TC_PS   = 10000;
    localparam int TP_PS   = TC_PS >> (PH_W + 1);
    localparam int SKEW_PS = 50;
    localparam int FULL    = PERIOD << (PH_W + 1);

    logic clk0 = 1'b0;
    logic clk_ph = 1'b0;
    logic rst_n = 1'b0;
    logic [DUTY_W-1:0] duty_in = '0;
    logic pwm_out;
    real  theta_ns = 0.05;
    real  last_rise = 0.0;
    real  prev_rise = 0.0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    dpwm_dual_edge #(.PERIOD(PERIOD), .DUTY_W(DUTY_W), .PH_W(PH_W)) i_dpwm_dual_edge (
        .clk0(clk0), .clk_ph(clk_ph), .rst_n(rst_n), .duty_in(duty_in), .pwm_out(pwm_out)
    );

    always #5 clk0 = ~clk0;
    always @(clk0) clk_ph <= #(theta_ns) clk0;

    always @(posedge pwm_out) begin
        prev_rise = last_rise;
        last_rise = $realtime;
    end

    function automatic int exp_width(input int d);
        return (d >> (PH_W + 1)) * TC_PS + (d % (1 << (PH_W + 1))) * TP_PS + SKEW_PS;
    endfunction

    task automatic check_near(input string tag, input int act, input int exp, input int tol);
        checks++;
        if (act > exp + tol || act < exp - tol) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_duty(input int d);
        duty_in  = DUTY_W'(d);
        theta_ns = (SKEW_PS + (d % (1 << PH_W)) * TP_PS) / 1000.0;
    endtask

    task automatic next_width(output int w);
        @(negedge pwm_out);
        w = int'(($realtime - last_rise) * 1000.0);
    endtask

    task automatic pulse_case(input int d, input string tag);
        int w;
        int per;
        set_duty(d);
        repeat (3 * PERIOD) @(negedge clk0);
        next_width(w);
        @(posedge pwm_out);
        #1;
        per = int'((last_rise - prev_rise) * 1000.0);
        check_near(tag, w, exp_width(d), 1);
        check_near("R2 period", per, PERIOD * TC_PS, 1);
    endtask

    task automatic level_case(input int d, input logic lvl, input string tag);
        int bad = 0;
        set_duty(d);
        repeat (3 * PERIOD) @(negedge clk0);
        repeat (2 * PERIOD) begin
            @(negedge clk0);
            if (pwm_out !== lvl) bad++;
        end
        check_near(tag, bad, 0, 0);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w;
        int bad;
        void'($urandom(32'd20240611));
        set_duty(85);
        repeat (5) @(negedge clk0);
        check_near("R1 reset low", int'(pwm_out), 0, 0);
        rst_n = 1'b1;
        bad = 0;
        repeat (PERIOD - 1) begin
            @(negedge clk0);
            if (pwm_out !== 1'b0) bad++;
        end
        check_near("R1 first period low", bad, 0, 0);

        pulse_case(85, "R4 example 5Tc+5Tp");
        pulse_case((1 << (PH_W + 1)), "R3 one coarse cycle");
        pulse_case((3 << (PH_W + 1)) | 5, "R4 rising edge");
        pulse_case((4 << (PH_W + 1)) | 8, "R5 falling edge phase 0");
        pulse_case(((PERIOD - 1) << (PH_W + 1)) | 15, "R5 longest non-full");
        pulse_case(FULL - 1, "R8 just below full");
        level_case(FULL, 1'b1, "R8 full word high");
        level_case((1 << DUTY_W) - 1, 1'b1, "R8 saturated high");
        pulse_case((2 << (PH_W + 1)) | 9, "R5 after full");
        level_case(0, 1'b0, "R9 zero word low");
        level_case(15, 1'b0, "R9 coarse zero fine set low");
        pulse_case((6 << (PH_W + 1)) | 2, "R4 after off");

        for (int i = 0; i < 24; i++) begin
            int c = 1 + int'($urandom % (PERIOD - 1));
            int f = int'($urandom % (1 << (PH_W + 1)));
            int d = (c << (PH_W + 1)) | f;
            if (f >= (1 << PH_W)) pulse_case(d, "R5 random");
            else                  pulse_case(d, "R4 random");
        end

        set_duty((10 << (PH_W + 1)) | 3);
        repeat (3 * PERIOD) @(negedge clk0);
        @(posedge pwm_out);
        repeat (2) @(negedge clk0);
        duty_in = DUTY_W'((5 << (PH_W + 1)) | 8 | 3);
        next_width(w);
        check_near("R7 mid-period keeps old", w, exp_width((10 << (PH_W + 1)) | 3), 1);
        next_width(w);
        check_near("R7 new word next period", w, exp_width((5 << (PH_W + 1)) | 11), 1);

        @(posedge pwm_out);
        repeat (PERIOD) @(negedge clk0);
        duty_in = DUTY_W'((7 << (PH_W + 1)) | 3);
        next_width(w);
        check_near("R7 write before wrap taken", w, exp_width((7 << (PH_W + 1)) | 3), 1);

        @(posedge pwm_out);
        repeat (PERIOD + 1) @(negedge clk0);
        duty_in = DUTY_W'((12 << (PH_W + 1)) | 8 | 3);
        next_width(w);
        check_near("R7 write after wrap deferred", w, exp_width((7 << (PH_W + 1)) | 3), 1);
        next_width(w);
        check_near("R7 deferred word applied", w, exp_width((12 << (PH_W + 1)) | 11), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule